// File: doc/BRIEF.md
# Endpoint FIFO Access Handshake

This block sits between a microcontroller register bus and two small endpoint buffers of a USB serial engine. The receive buffer is filled by the serial engine and drained by the microcontroller. The transmit buffer is filled by the microcontroller and drained by the serial engine. The microcontroller never touches either buffer directly. It writes a control byte that selects a buffer, raises a request and toggles a direction strobe. It reads back the same byte with a data-ready flag and a zero-length-packet flag added. Data moves through a separate byte-wide data port.

A pacing timer keeps the ready flag low for a fixed number of clock cycles after each request edge and after each accepted data access. A data access made while the timer runs, or while the selected buffer cannot serve it, has no effect and sets an error flag. The transaction ends with a strobe edge. On the transmit side, the falling edge of the strobe commits the written bytes, or an empty packet, toward the engine. On the receive side, the rising edge of the strobe hands the buffer back to the engine so it can refill it. A push/pop stub port stands in for the serial engine.

Top module: `ep_fifo_port`

## Requirements
- R1: After reset the status byte reads 00h, the receive side reports free (`rx_free`=1) and no transmit packet is pending (`tx_valid`=0).
- R2: Control bits are request (bit 0), direction strobe (bit 1), zero-length command (bit 2) and transmit-buffer select (bit 3). They read back at those positions. Bit 4 is the access-error flag, bit 5 reads 0, bit 6 is ready and bit 7 is receive zero-length pending.
- R3: Ready stays 0 for GAP clock cycles after a control write that raises the request, and for GAP cycles after each accepted data access.
- R4: With the request high and the receive buffer selected, ready is 1 only once the engine has ended a packet and at least one byte of it remains. Otherwise the status reads 01h, with the error bit added if it is set.
- R5: With the request high and the transmit buffer selected, ready is 1 only while no committed packet awaits the engine and the buffer has room: 4Bh, else 0Bh.
- R6: An accepted data-port read returns the oldest unread receive byte, in the engine's push order, and advances to the next.
- R7: A packet ended with no bytes gives status 81h on a receive request. One data read discards it, and the status then reads 01h.
- R8: A rising strobe edge while the request stays high on the receive buffer drops the remaining bytes and returns the buffer to the engine (`rx_free`=1).
- R9: A falling strobe edge while the request stays high on the transmit buffer commits the written bytes as one packet, offered in write order. If bit 2 is set in that write, an empty packet is committed (`tx_empty_pkt`=1).
- R10: A data access that is not accepted changes no buffer or timer and sets bit 4. The next rising request edge clears bit 4.
- R11: Engine pushes are dropped while a receive packet is pending or the buffer is full. Ending a packet with no bytes marks it as zero-length.
- R12: `tx_done` clears the pending transmit packet and its bytes, which makes the transmit buffer writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte; bits 7:4 ignored |
| ctl_rdata | output | 8 | Status byte |
| dat_re | input | 1 | Data-port read strobe |
| dat_rdata | output | W | Oldest receive byte |
| dat_we | input | 1 | Data-port write strobe |
| dat_wdata | input | W | Byte to transmit buffer |
| rx_push | input | 1 | Engine pushes one receive byte |
| rx_byte | input | W | Engine receive byte |
| rx_end | input | 1 | Engine ends the receive packet |
| rx_free | output | 1 | Receive buffer accepts a new packet |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_done | input | 1 | Engine finished the transmit packet |
| tx_byte | output | W | Oldest transmit byte |
| tx_valid | output | 1 | Transmit packet committed |
| tx_empty_pkt | output | 1 | Committed packet has no bytes left |

## Verification
The bench builds the block with DEPTH=4 and GAP=6 instead of the defaults. A four-entry buffer lets a short run fill the transmit side and overflow the receive side, so the full and dropped-push cases are reached. A six-cycle pacing window is long enough to place a data access inside it, and short enough that every sequence runs to completion. A behavioural queue model is compared with the status byte and the engine-side outputs on every clock. Directed checks cover the read-back values of each handshake sequence.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef struct packed {
    logic sel;   // bit 3: transmit buffer selected
    logic zl;    // bit 2: zero-length command
    logic dir;   // bit 1: direction strobe
    logic req;   // bit 0: request
  } ctl_t;

  localparam int STAT_ERR = 4;
  localparam int STAT_RDY = 6;
  localparam int STAT_ZLP = 7;
endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          clear,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clear) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = step(wr_q);
      if (pop)  rd_d = step(rd_q);
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign count = cnt_q;

  // R11: the gating in front of this buffer never pushes into a full buffer
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |-> (cnt_q != CW'(DEPTH)));
  // R6: the gating never pops an empty buffer
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |-> (cnt_q != '0));
endmodule

// File: rtl/ep_pace_timer.sv
module ep_pace_timer #(
  parameter int GAP  = 500,
  localparam int CW  = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = CW'(GAP);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ep_fifo_port.sv
module ep_fifo_port #(
  parameter int DEPTH = 8,
  parameter int GAP   = 500,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  logic [7:0]   ctl_wdata,
  output logic [7:0]   ctl_rdata,
  input  logic         dat_re,
  output logic [W-1:0] dat_rdata,
  input  logic         dat_we,
  input  logic [W-1:0] dat_wdata,
  input  logic         rx_push,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_end,
  output logic         rx_free,
  input  logic         tx_pop,
  input  logic         tx_done,
  output logic [W-1:0] tx_byte,
  output logic         tx_valid,
  output logic         tx_empty_pkt
);
  import ep_pkg::*;

  ctl_t ctl_q, ctl_d, ctl_in;
  logic rx_pend_q, rx_pend_d, rx_zlp_q, rx_zlp_d;
  logic tx_pend_q, tx_pend_d, err_q, err_d;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic busy, unused_hi;

  assign ctl_in    = ctl_t'(ctl_wdata[3:0]);
  assign unused_hi = ^ctl_wdata[7:4];

  // control edges
  logic req_rise, hold, dir_fall, dir_rise, commit, release_rx;
  assign req_rise   = ctl_we && ctl_in.req && !ctl_q.req;
  assign hold       = ctl_we && ctl_q.req && ctl_in.req;
  assign dir_fall   = hold && ctl_q.dir && !ctl_in.dir;
  assign dir_rise   = hold && !ctl_q.dir && ctl_in.dir;
  assign commit     = dir_fall && ctl_q.sel;
  assign release_rx = dir_rise && !ctl_q.sel;

  // readiness and access acceptance
  logic open, rd_go, wr_go, rdy_bit, zlp_bit, rd_acc, wr_acc, reject;
  assign open    = ctl_q.req && !busy;
  assign rd_go   = open && !ctl_q.sel && rx_pend_q && ((rx_cnt != '0) || rx_zlp_q);
  assign wr_go   = open && ctl_q.sel && !tx_pend_q && (tx_cnt != CW'(DEPTH));
  assign rdy_bit = wr_go || (open && !ctl_q.sel && rx_pend_q && (rx_cnt != '0));
  assign zlp_bit = open && !ctl_q.sel && rx_pend_q && rx_zlp_q;
  assign rd_acc  = dat_re && rd_go;
  assign wr_acc  = dat_we && wr_go;
  assign reject  = (dat_re || dat_we) && !rd_acc && !wr_acc;

  ep_pace_timer #(.GAP(GAP)) u_pace (
    .clk(clk), .rst_n(rst_n),
    .load(req_rise || rd_acc || wr_acc),
    .busy(busy)
  );

  // receive buffer
  logic rx_push_ok;
  assign rx_push_ok = rx_push && !rx_pend_q && (rx_cnt != CW'(DEPTH));

  ep_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push_ok), .din(rx_byte),
    .pop(rd_acc && !rx_zlp_q), .clear(release_rx),
    .dout(dat_rdata), .count(rx_cnt)
  );

  // transmit buffer
  ep_byte_fifo #(.DEPTH(DEPTH), .W(W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .push(wr_acc), .din(dat_wdata),
    .pop(tx_pop && tx_pend_q && (tx_cnt != '0)),
    .clear((commit && ctl_in.zl) || (tx_done && tx_pend_q)),
    .dout(tx_byte), .count(tx_cnt)
  );

  // next state
  always_comb begin
    ctl_d     = ctl_we ? ctl_in : ctl_q;
    rx_pend_d = rx_pend_q;
    rx_zlp_d  = rx_zlp_q;
    tx_pend_d = tx_pend_q;
    err_d     = err_q;
    if (release_rx) begin
      rx_pend_d = 1'b0;
      rx_zlp_d  = 1'b0;
    end else if (rd_acc) begin
      rx_zlp_d  = 1'b0;
    end else if (rx_end && !rx_pend_q) begin
      rx_pend_d = 1'b1;
      rx_zlp_d  = (rx_cnt == '0) && !rx_push_ok;
    end
    if (commit)                    tx_pend_d = 1'b1;
    else if (tx_done && tx_pend_q) tx_pend_d = 1'b0;
    if (req_rise)    err_d = 1'b0;
    else if (reject) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      rx_pend_q <= 1'b0;
      rx_zlp_q  <= 1'b0;
      tx_pend_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      rx_pend_q <= rx_pend_d;
      rx_zlp_q  <= rx_zlp_d;
      tx_pend_q <= tx_pend_d;
      err_q     <= err_d;
    end
  end

  assign ctl_rdata    = {zlp_bit, rdy_bit, 1'b0, err_q, ctl_q};
  assign rx_free      = !rx_pend_q;
  assign tx_valid     = tx_pend_q;
  assign tx_empty_pkt = tx_pend_q && (tx_cnt == '0);

  // R3: settling window after a request edge and after an access
  a_r3_settle_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> !ctl_rdata[STAT_RDY]);
  a_r3_settle_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc || wr_acc) |=> !ctl_rdata[STAT_RDY]);
  // R7: zero-length status never shows together with ready
  a_r7_zlp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[STAT_ZLP] |-> (!ctl_rdata[STAT_RDY] && rx_cnt == '0));
  // R11: a pending receive packet is not grown by the engine
  a_r11_rx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend_q && !release_rx && !rd_acc) |=> $stable(rx_cnt));
  // R9: a commit leaves a packet pending
  a_r9_commit_pends: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> tx_valid);
  // R10: a refused access raises the error flag
  a_r10_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !req_rise) |=> ctl_rdata[STAT_ERR]);
endmodule

// File: tb/sim_ep_fifo_port.sv
`timescale 1ns/1ps
module sim_ep_fifo_port;
  localparam int DEPTH = 4;
  localparam int GAP   = 6;
  localparam int W     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, dat_re = 1'b0, dat_we = 1'b0;
  logic rx_push = 1'b0, rx_end = 1'b0, tx_pop = 1'b0, tx_done = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [W-1:0] dat_wdata = '0, rx_byte = '0;
  logic [7:0] ctl_rdata;
  logic [W-1:0] dat_rdata, tx_byte;
  logic rx_free, tx_valid, tx_empty_pkt;

  always #2 clk = ~clk;

  ep_fifo_port #(.DEPTH(DEPTH), .GAP(GAP), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .dat_re(dat_re), .dat_rdata(dat_rdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_end(rx_end), .rx_free(rx_free),
    .tx_pop(tx_pop), .tx_done(tx_done), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_empty_pkt(tx_empty_pkt)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] mc;
  bit merr, mrxp, mrxz, mtxp;
  int mbusy;
  logic [W-1:0] rxq[$], txq[$];

  function automatic logic [7:0] m_status();
    bit op, rb, zb;
    op = mc[0] && (mbusy == 0);
    rb = op && (mc[3] ? (!mtxp && txq.size() < DEPTH) : (mrxp && rxq.size() > 0));
    zb = op && !mc[3] && mrxp && mrxz;
    return {zb, rb, 1'b0, merr, mc};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc = '0; merr = 0; mrxp = 0; mrxz = 0; mtxp = 0; mbusy = 0;
      rxq.delete(); txq.delete();
    end else begin
      bit op, rd_go, wr_go, acc_rd, acc_wr, rej, rr, hold, cm, fr, push_ok, pre_rxp, pre_txp;
      int pre_rx, pre_tx;
      logic [3:0] nc;
      op     = mc[0] && (mbusy == 0);
      rd_go  = op && !mc[3] && mrxp && (rxq.size() > 0 || mrxz);
      wr_go  = op && mc[3] && !mtxp && (txq.size() < DEPTH);
      acc_rd = dat_re && rd_go;
      acc_wr = dat_we && wr_go;
      rej    = (dat_re || dat_we) && !acc_rd && !acc_wr;
      nc     = ctl_wdata[3:0];
      rr     = ctl_we && nc[0] && !mc[0];
      hold   = ctl_we && mc[0] && nc[0];
      cm     = hold && mc[1] && !nc[1] && mc[3];
      fr     = hold && !mc[1] && nc[1] && !mc[3];
      pre_rx = rxq.size(); pre_rxp = mrxp; pre_tx = txq.size(); pre_txp = mtxp;
      push_ok = rx_push && !pre_rxp && (pre_rx < DEPTH);
      if (fr) begin
        rxq.delete(); mrxp = 0; mrxz = 0;
      end else begin
        if (acc_rd) begin
          if (mrxz) mrxz = 0; else void'(rxq.pop_front());
        end
        if (push_ok) rxq.push_back(rx_byte);
        if (rx_end && !pre_rxp) begin
          mrxp = 1; mrxz = (pre_rx == 0) && !push_ok;
        end
      end
      if (acc_wr) txq.push_back(dat_wdata);
      if (tx_pop && pre_txp && pre_tx > 0) void'(txq.pop_front());
      if (tx_done && pre_txp) begin mtxp = 0; txq.delete(); end
      if (cm) begin mtxp = 1; if (nc[2]) txq.delete(); end
      if (rr || acc_rd || acc_wr) mbusy = GAP;
      else if (mbusy > 0) mbusy--;
      if (rr) merr = 0; else if (rej) merr = 1;
      if (ctl_we) mc = nc;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 status", ctl_rdata, m_status());
      if (rxq.size() > 0) chk("R6 rdata", dat_rdata, rxq[0]);
      if (txq.size() > 0) chk("R9 tx_byte", tx_byte, txq[0]);
      chk("R9 tx_valid", {7'd0, tx_valid}, {7'd0, mtxp});
      chk("R9 tx_empty", {7'd0, tx_empty_pkt}, {7'd0, mtxp && txq.size() == 0});
      chk("R11 rx_free", {7'd0, rx_free}, {7'd0, !mrxp});
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks (entered at a negedge) ----------------
  task automatic ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
  endtask
  task automatic rd();
    dat_re = 1; @(negedge clk); dat_re = 0;
  endtask
  task automatic wr(input logic [7:0] v);
    dat_we = 1; dat_wdata = v; @(negedge clk); dat_we = 0;
  endtask
  task automatic spush(input logic [7:0] v);
    rx_push = 1; rx_byte = v; @(negedge clk); rx_push = 0;
  endtask
  task automatic send();
    rx_end = 1; @(negedge clk); rx_end = 0;
  endtask
  task automatic settle();
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 status", ctl_rdata, 8'h00);
    chk("R1 rx_free", {7'd0, rx_free}, 8'h01);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    ctl(8'h0A); chk("R2 readback", ctl_rdata, 8'h0A);
    ctl(8'h00);

    // receive three bytes; a fourth after the end is dropped
    spush(8'hA1); spush(8'hA2); spush(8'hA3); send();
    chk("R11 pending", {7'd0, rx_free}, 8'h00);
    spush(8'hA4);
    ctl(8'h00); ctl(8'h01);
    chk("R3 settle after request", ctl_rdata, 8'h01);
    settle(); chk("R4 read ready", ctl_rdata, 8'h41);
    chk("R6 first byte", dat_rdata, 8'hA1);
    rd(); chk("R3 settle after read", ctl_rdata, 8'h01);
    rd(); chk("R10 early read flagged", ctl_rdata, 8'h11);
    settle(); chk("R10 early read ignored", dat_rdata, 8'hA2);
    rd(); settle(); chk("R6 third byte", dat_rdata, 8'hA3);
    rd(); settle(); chk("R4 drained, R11 A4 dropped", ctl_rdata, 8'h11);
    ctl(8'h03); chk("R8 buffer released", {7'd0, rx_free}, 8'h01);
    ctl(8'h02); chk("R2 release", ctl_rdata, 8'h12);

    // zero-length receive packet
    send(); ctl(8'h00); ctl(8'h01); settle();
    chk("R7 zlp status", ctl_rdata, 8'h81);
    rd(); chk("R7 after dummy read", ctl_rdata, 8'h01);
    settle(); chk("R7 zlp consumed", ctl_rdata, 8'h01);
    ctl(8'h03); ctl(8'h02);
    chk("R8 released after zlp", {7'd0, rx_free}, 8'h01);

    // transmit a full packet
    ctl(8'h0A); ctl(8'h0B); settle();
    chk("R5 write ready", ctl_rdata, 8'h4B);
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'hB0 + 8'(i));
      if (i == 0) chk("R3 settle after write", ctl_rdata, 8'h0B);
      settle();
    end
    chk("R5 full", ctl_rdata, 8'h0B);
    ctl(8'h09);
    chk("R9 committed", {7'd0, tx_valid}, 8'h01);
    chk("R9 first tx byte", tx_byte, 8'hB0);
    ctl(8'h08); ctl(8'h0A); ctl(8'h0B); settle();
    chk("R5 pending probe", ctl_rdata, 8'h0B);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R9 tx order", tx_byte, 8'hB0 + 8'(i));
      tx_pop = 1; @(negedge clk); tx_pop = 0;
    end
    tx_done = 1; @(negedge clk); tx_done = 0;
    chk("R12 cleared", {7'd0, tx_valid}, 8'h00);
    chk("R12 writable again", ctl_rdata, 8'h4B);

    // zero-length transmit
    ctl(8'h0F); ctl(8'h0D);
    chk("R9 empty packet", {6'd0, tx_valid, tx_empty_pkt}, 8'h03);
    ctl(8'h08);
    tx_done = 1; @(negedge clk); tx_done = 0;

    // refused accesses
    ctl(8'h00); wr(8'h55);
    chk("R10 write without request", ctl_rdata, 8'h10);
    chk("R10 nothing queued", {7'd0, tx_valid}, 8'h00);
    ctl(8'h0A); ctl(8'h0B); settle();
    rd(); chk("R10 wrong direction", ctl_rdata, 8'h5B);
    ctl(8'h08);

    // engine overfills the receive buffer
    for (int i = 0; i < DEPTH + 1; i++) spush(8'hC0 + 8'(i));
    send(); ctl(8'h00); ctl(8'h01); settle();
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11 kept bytes", dat_rdata, 8'hC0 + 8'(i));
      rd(); settle();
    end
    chk("R11 overflow byte dropped", ctl_rdata, 8'h01);
    ctl(8'h03); ctl(8'h02);
    repeat (2) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule